// File: doc/BRIEF.md
# Predicated Nested Element Loop Sequencer

This block turns one scalar instruction into a run of element steps. The outer loop counts vector elements from zero up to the vector length (VL). Inside it, a second loop counts sub-elements, from zero up to the sub-vector length (SUBVL). The block presents one step per cycle. Each step carries a source element index, a destination element index, a sub-element index, a write enable and a write-zero strobe. The register file and the execution unit read these fields and act on them. A separate done pulse marks the end of the run.

A single predicate bit gates each element, and that bit covers every sub-element of the element's group. The mask can be used complemented, and masked-off positions can be forced to zero or left as they were. In fail-on-first mode the consumer reports a data-dependent failure for the step it is executing. The block then cancels that step and every later one, and records the index of the failing element. A run can resume from saved source, destination and sub-element offsets, so a trapped sequence continues where it stopped. A stall input holds the presented step until the consumer takes it.

Top module: `vec_elem_seq`

## Requirements
- R1: After `start` is sampled in idle, the first step appears after the next clock edge. Without stall, one step follows per cycle in nested order. For each element, sub-element index 0 up to `subvl_m1` comes first, and then the element index increments. A run has (`vl_m1`+1)·(`subvl_m1`+1) steps.
- R2: Predicate bit i of `pmask` applies to destination element i. The same bit gates every sub-element step of that element.
- R3: When `pinv` is 1, the complemented mask bit is used. `pmask`, `pinv` and `pzero` are captured at start, and changing them during a run has no effect on that run.
- R4: A step whose effective predicate bit is 1 has `wr_en`=1 and `wr_zero`=0. A masked-off step has `wr_zero`=`pzero` and `wr_en`=0. The two strobes are never both high.
- R5: An operand flagged as vector (`src_vec`/`dst_vec`=1) presents its element offset as its index. An operand flagged as scalar presents index 0 on every step.
- R6: With `ff_en`=1, `elem_fail` is counted only on a valid, predicated, unstalled step. When it is counted, `wr_en` drops in that same cycle and no further step is presented. `done`, `ff_hit`=1 and `ff_idx`=the failing element index follow on the next cycle. With `ff_en`=0, `elem_fail` has no effect.
- R7: With VL=1 and SUBVL=1, exactly one step with all indices 0 is presented, followed by `done`.
- R8: While `stall` is high, the presented step and its indices hold, and no step is skipped.
- R9: `done` is a one-cycle pulse in the cycle after the last step. `start` is ignored while a run is in progress.
- R10: With `resume`=1 at start, the source, destination and sub-element counters load from `rs_src`, `rs_dst` and `rs_sub`. The source and destination offsets then advance together once per completed group.
- R11: During and right after reset, `step_valid`, `wr_en`, `wr_zero`, `done` and `ff_hit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken only when idle) |
| resume | input | 1 | At start, load offsets from the restart inputs |
| vl_m1 | input | IW | Vector length minus one |
| subvl_m1 | input | SW | Sub-vector length minus one |
| src_vec | input | 1 | Source operand is a vector |
| dst_vec | input | 1 | Destination operand is a vector |
| pmask | input | MAXVL | Predicate mask, one bit per element |
| pinv | input | 1 | Use the complemented mask |
| pzero | input | 1 | Zero masked-off positions |
| ff_en | input | 1 | Fail-on-first mode |
| elem_fail | input | 1 | Failure reported for the presented step |
| stall | input | 1 | Consumer cannot take the presented step |
| rs_src | input | IW | Restart source element offset |
| rs_dst | input | IW | Restart destination element offset |
| rs_sub | input | SW | Restart sub-element offset |
| step_valid | output | 1 | A step is presented |
| src_idx | output | IW | Source element index |
| dst_idx | output | IW | Destination element index |
| sub_idx | output | SW | Sub-element index |
| wr_en | output | 1 | Write the result of this step |
| wr_zero | output | 1 | Write zero at this position |
| done | output | 1 | One-cycle pulse after the run ends |
| ff_hit | output | 1 | Last run stopped on a fail-on-first event |
| ff_idx | output | IW | Element index at which the run stopped |

## Verification
A wrong nesting counter shows up within one step as a sub-index that never wraps or an element index that moves too early. A run of the wrong length shifts the cycle in which `done` appears. Predicate, inversion and zeroing faults show up in the strobes on the very step of the affected element. Faults in stall or fail-on-first handling show up one cycle after the event, as a moved index, an extra step or a missing `done`. Every step of each stimulus vector is compared in its own cycle, so a fault becomes visible at the first step where the counters go wrong.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_st_t;
endpackage

// File: rtl/seq_nest_cnt.sv
module seq_nest_cnt #(
  parameter int IW = 4,
  parameter int CW = 5,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  input  logic [IW-1:0] src_ld,
  input  logic [CW-1:0] dst_ld,
  input  logic [SW-1:0] sub_ld,
  input  logic [SW-1:0] sub_last,
  output logic [IW-1:0] src_el,
  output logic [CW-1:0] dst_el,
  output logic [SW-1:0] sub_el
);
  // Inner sub-element counter wraps at sub_last; element counters step on wrap.
  always_ff @(posedge clk) begin
    if (rst) begin
      src_el <= '0;
      dst_el <= '0;
      sub_el <= '0;
    end else if (load) begin
      src_el <= src_ld;
      dst_el <= dst_ld;
      sub_el <= sub_ld;
    end else if (adv) begin
      if (sub_el == sub_last) begin
        sub_el <= '0;
        src_el <= src_el + IW'(1);
        dst_el <= dst_el + CW'(1);
      end else begin
        sub_el <= sub_el + SW'(1);
      end
    end
  end

  AST_SUB_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && sub_el == sub_last) |=> (sub_el == '0)); // R1
  AST_ELEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && sub_el != sub_last) |=> (dst_el == $past(dst_el))); // R1
endmodule

// File: rtl/seq_pred.sv
module seq_pred #(
  parameter int NE = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [NE-1:0] mask_in,
  input  logic          inv_in,
  input  logic          zero_in,
  input  logic [IW-1:0] idx,
  output logic          act,
  output logic          zero_mode
);
  logic [NE-1:0] mask_q;
  logic          inv_q;

  // Private copy of the mask; inversion is applied on read only.
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      inv_q     <= 1'b0;
      zero_mode <= 1'b0;
    end else if (load) begin
      mask_q    <= mask_in;
      inv_q     <= inv_in;
      zero_mode <= zero_in;
    end
  end

  assign act = mask_q[idx] ^ inv_q;

  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!load && !$past(load)) |-> ($stable(mask_q) && $stable(inv_q))); // R3
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import seq_pkg::*;
#(
  parameter int MAXVL  = 16,
  parameter int MAXSUB = 4,
  localparam int IW = $clog2(MAXVL),
  localparam int CW = $clog2(MAXVL + 1),
  localparam int SW = $clog2(MAXSUB)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             resume,
  input  logic [IW-1:0]    vl_m1,
  input  logic [SW-1:0]    subvl_m1,
  input  logic             src_vec,
  input  logic             dst_vec,
  input  logic [MAXVL-1:0] pmask,
  input  logic             pinv,
  input  logic             pzero,
  input  logic             ff_en,
  input  logic             elem_fail,
  input  logic             stall,
  input  logic [IW-1:0]    rs_src,
  input  logic [IW-1:0]    rs_dst,
  input  logic [SW-1:0]    rs_sub,
  output logic             step_valid,
  output logic [IW-1:0]    src_idx,
  output logic [IW-1:0]    dst_idx,
  output logic [SW-1:0]    sub_idx,
  output logic             wr_en,
  output logic             wr_zero,
  output logic             done,
  output logic             ff_hit,
  output logic [IW-1:0]    ff_idx
);
  seq_st_t       st;
  logic [CW-1:0] vl_q;
  logic [SW-1:0] sub_last_q;
  logic          svec_q, dvec_q, ff_q;
  logic          valid_q, en_q, zq_q;
  logic [IW-1:0] el_q;

  logic          go, more, fail_now, fail_take, take_next, adv;
  logic [IW-1:0] src_el;
  logic [CW-1:0] dst_el;
  logic [SW-1:0] sub_el;
  logic          act, zero_mode;

  assign go        = start && (st == ST_IDLE);
  assign more      = dst_el < vl_q;
  assign fail_now  = valid_q && ff_q && en_q && elem_fail;
  assign fail_take = fail_now && !stall;
  assign take_next = (st == ST_RUN) && !fail_take && (!valid_q || !stall);
  assign adv       = take_next && more;

  seq_nest_cnt #(.IW(IW), .CW(CW), .SW(SW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (go),
    .adv      (adv),
    .src_ld   (resume ? rs_src : '0),
    .dst_ld   (resume ? CW'(rs_dst) : '0),
    .sub_ld   (resume ? rs_sub : '0),
    .sub_last (sub_last_q),
    .src_el   (src_el),
    .dst_el   (dst_el),
    .sub_el   (sub_el)
  );

  seq_pred #(.NE(MAXVL), .IW(IW)) u_pred (
    .clk       (clk),
    .rst       (rst),
    .load      (go),
    .mask_in   (pmask),
    .inv_in    (pinv),
    .zero_in   (pzero),
    .idx       (dst_el[IW-1:0]),
    .act       (act),
    .zero_mode (zero_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      vl_q       <= '0;
      sub_last_q <= '0;
      svec_q     <= 1'b0;
      dvec_q     <= 1'b0;
      ff_q       <= 1'b0;
      valid_q    <= 1'b0;
      en_q       <= 1'b0;
      zq_q       <= 1'b0;
      el_q       <= '0;
      src_idx    <= '0;
      dst_idx    <= '0;
      sub_idx    <= '0;
      done       <= 1'b0;
      ff_hit     <= 1'b0;
      ff_idx     <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            vl_q       <= CW'(vl_m1) + CW'(1);
            sub_last_q <= subvl_m1;
            svec_q     <= src_vec;
            dvec_q     <= dst_vec;
            ff_q       <= ff_en;
            ff_hit     <= 1'b0;
            ff_idx     <= '0;
            st         <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (fail_take) begin
            valid_q <= 1'b0;
            en_q    <= 1'b0;
            zq_q    <= 1'b0;
            ff_hit  <= 1'b1;
            ff_idx  <= el_q;
            done    <= 1'b1;
            st      <= ST_IDLE;
          end else if (take_next) begin
            if (more) begin
              valid_q <= 1'b1;
              el_q    <= dst_el[IW-1:0];
              src_idx <= svec_q ? src_el : '0;
              dst_idx <= dvec_q ? dst_el[IW-1:0] : '0;
              sub_idx <= sub_el;
              en_q    <= act;
              zq_q    <= !act && zero_mode;
            end else begin
              valid_q <= 1'b0;
              en_q    <= 1'b0;
              zq_q    <= 1'b0;
              done    <= 1'b1;
              st      <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign step_valid = valid_q;
  assign wr_en      = en_q && !fail_now;
  assign wr_zero    = zq_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_zero)); // R4
  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (rst)
    step_valid |-> (sub_idx <= sub_last_q)); // R1
  AST_SCALAR_SRC: assert property (@(posedge clk) disable iff (rst)
    (step_valid && !svec_q) |-> (src_idx == '0)); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (step_valid && stall) |=> (step_valid && $stable(dst_idx) && $stable(sub_idx) && $stable(src_idx))); // R8
  AST_FAIL_STOP: assert property (@(posedge clk) disable iff (rst)
    (fail_now && !stall) |=> (!step_valid && done && ff_hit)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !step_valid); // R9
endmodule

// File: tb/tb_vec_elem_seq.sv
module tb_vec_elem_seq;
  localparam int MAXVL = 16;
  localparam int IW = 4;
  localparam int SW = 2;

  typedef struct packed {
    logic [3:0]  vlm1;
    logic [1:0]  sm1;
    logic [15:0] mask;
    logic        inv;
    logic        zr;
    logic        sv;
    logic        dv;
  } vec_t;

  localparam vec_t TBL [0:5] = '{
    '{4'd3,  2'd0, 16'h000A, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'd2,  2'd3, 16'h0005, 1'b0, 1'b1, 1'b1, 1'b1},
    '{4'd4,  2'd1, 16'h0005, 1'b1, 1'b1, 1'b0, 1'b1},
    '{4'd15, 2'd0, 16'hF0F0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{4'd0,  2'd0, 16'h0001, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'd1,  2'd2, 16'h0002, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, resume = 1'b0;
  logic [IW-1:0] vl_m1 = '0;
  logic [SW-1:0] subvl_m1 = '0;
  logic src_vec = 1'b0, dst_vec = 1'b0;
  logic [MAXVL-1:0] pmask = '0;
  logic pinv = 1'b0, pzero = 1'b0, ff_en = 1'b0, elem_fail = 1'b0, stall = 1'b0;
  logic [IW-1:0] rs_src = '0, rs_dst = '0;
  logic [SW-1:0] rs_sub = '0;
  logic step_valid, wr_en, wr_zero, done, ff_hit;
  logic [IW-1:0] src_idx, dst_idx, ff_idx;
  logic [SW-1:0] sub_idx;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vec_elem_seq dut (
    .clk(clk), .rst(rst), .start(start), .resume(resume), .vl_m1(vl_m1),
    .subvl_m1(subvl_m1), .src_vec(src_vec), .dst_vec(dst_vec), .pmask(pmask),
    .pinv(pinv), .pzero(pzero), .ff_en(ff_en), .elem_fail(elem_fail),
    .stall(stall), .rs_src(rs_src), .rs_dst(rs_dst), .rs_sub(rs_sub),
    .step_valid(step_valid), .src_idx(src_idx), .dst_idx(dst_idx),
    .sub_idx(sub_idx), .wr_en(wr_en), .wr_zero(wr_zero), .done(done),
    .ff_hit(ff_hit), .ff_idx(ff_idx)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic setup(input vec_t v);
    vl_m1 = v.vlm1; subvl_m1 = v.sm1; pmask = v.mask; pinv = v.inv;
    pzero = v.zr; src_vec = v.sv; dst_vec = v.dv;
  endtask

  // Full run checked step by step against a model of the requirements.
  task automatic run_seq(input vec_t v, input bit res, input int rsrc,
                         input int rdst, input int rsub, input bit poke,
                         input bit noise);
    int el, se, sb, k;
    bit pb;
    setup(v);
    ff_en = 1'b0;
    resume = res; rs_src = IW'(rsrc); rs_dst = IW'(rdst); rs_sub = SW'(rsub);
    start = 1'b1;
    tick();
    start = 1'b0; resume = 1'b0;
    if (poke) begin
      pmask = ~pmask; pinv = ~pinv; pzero = ~pzero; vl_m1 = '0; // R3 R9
    end
    elem_fail = noise; // R6: ignored with fail-on-first off
    el = rdst; se = rsrc; sb = rsub; k = 0;
    while (el <= int'(v.vlm1)) begin
      tick();
      pb = v.mask[el] ^ v.inv;
      chk("R1 valid", int'(step_valid), 1);
      chk("R1 sub_idx", int'(sub_idx), sb);
      chk("R5 dst_idx", int'(dst_idx), v.dv ? el : 0);
      chk("R10 src_idx", int'(src_idx), v.sv ? (se % MAXVL) : 0);
      chk("R2 wr_en", int'(wr_en), int'(pb));
      chk("R4 wr_zero", int'(wr_zero), int'(!pb && v.zr));
      if (poke && k == 0) start = 1'b1;
      if (poke && k == 1) start = 1'b0;
      k++;
      sb++;
      if (sb > int'(v.sm1)) begin sb = 0; el++; se++; end
    end
    start = 1'b0;
    tick();
    chk("R9 done", int'(done), 1);
    chk("R1 end valid", int'(step_valid), 0);
    chk("R6 ff_hit", int'(ff_hit), 0);
    elem_fail = 1'b0;
    tick();
    chk("R9 done pulse", int'(done), 0);
    chk("R9 no restart", int'(step_valid), 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) tick();
    chk("R11 valid", int'(step_valid), 0);
    chk("R11 done", int'(done), 0);
    chk("R11 wr", int'(wr_en | wr_zero), 0);
    rst = 1'b0;
    tick();
    chk("R11 after", int'(step_valid | done | ff_hit), 0);

    for (int i = 0; i < 6; i++) begin
      run_seq(TBL[i], 1'b0, 0, 0, 0, 1'b0, 1'b0); // R7 is entry 4
    end

    // R3 and R9: inputs scrambled and start pulsed mid-run
    run_seq('{4'd3, 2'd1, 16'h0003, 1'b0, 1'b1, 1'b1, 1'b1}, 1'b0, 0, 0, 0, 1'b1, 1'b0);
    // R6: fail indication ignored when fail-on-first is off
    run_seq('{4'd2, 2'd1, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1}, 1'b0, 0, 0, 0, 1'b0, 1'b1);
    // R10: resume from saved offsets
    run_seq('{4'd4, 2'd1, 16'h0015, 1'b0, 1'b1, 1'b1, 1'b1}, 1'b1, 3, 2, 1, 1'b0, 1'b0);
    // R10: resume past the end gives no steps
    run_seq('{4'd1, 2'd0, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1}, 1'b1, 0, 2, 0, 1'b0, 1'b0);

    // R8 stall holds the step
    setup('{4'd2, 2'd0, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1});
    start = 1'b1; tick(); start = 1'b0;
    tick();
    chk("R8 first", int'(dst_idx), 0);
    stall = 1'b1;
    tick();
    chk("R8 hold valid", int'(step_valid), 1);
    chk("R8 hold idx", int'(dst_idx), 0);
    tick();
    chk("R8 hold idx2", int'(dst_idx), 0);
    stall = 1'b0;
    tick();
    chk("R8 next", int'(dst_idx), 1);
    tick();
    chk("R8 last", int'(dst_idx), 2);
    tick();
    chk("R8 done", int'(done), 1);
    tick();

    // R6 fail-on-first stops at element 2
    setup('{4'd5, 2'd1, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1});
    ff_en = 1'b1;
    start = 1'b1; tick(); start = 1'b0;
    repeat (5) tick();
    chk("R6 at step", int'(dst_idx), 2);
    chk("R6 pre wr_en", int'(wr_en), 1);
    elem_fail = 1'b1;
    #1;
    chk("R6 cancel wr_en", int'(wr_en), 0);
    tick();
    elem_fail = 1'b0;
    chk("R6 stopped", int'(step_valid), 0);
    chk("R6 done", int'(done), 1);
    chk("R6 ff_hit", int'(ff_hit), 1);
    chk("R6 ff_idx", int'(ff_idx), 2);
    tick();
    chk("R6 no more", int'(step_valid | done), 0);
    ff_en = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule